// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by reading two levels of translation tables that live in main memory. A base register holds the byte address where the current process's directory starts. The upper page-number field of the virtual address selects a directory entry. That entry names the page frame holding a second-level table, and each such table fills exactly one page. The lower page-number field selects an entry in that table. The entry gives the frame number, which is joined to the unchanged byte offset.

Requests arrive on a valid/ready port and results leave on a second valid/ready port. A walk issues its table reads through a memory read port. The read port has a valid/ready request channel and a valid/ready response channel, and only one read is in flight at any time. An entry whose present bit is clear ends the walk with a fault response that names the level where it stopped. The walker handles one translation at a time. Software changes the base register through a plain write strobe. The write is taken only while the walker is idle, and it governs the next request.

Back-pressure rules:
- A request is taken on a cycle where `req_valid` and `req_ready` are both high.
- `rsp_valid` stays high until `rsp_ready` is seen high, and the response fields stay unchanged for that whole time.
- `mem_req_valid` and `mem_req_addr` stay unchanged until `mem_req_ready`.
- The memory may delay `mem_rsp_valid` for any number of cycles. `mem_rsp_ready` is high only while the walker waits for that data.

Top module: `pgwalk_top`

## Requirements
- R1: Virtual address layout from bit 0 upward: a 9-bit byte offset, then a 7-bit table index (TBL_W = OFF_W - log2(entry bytes)), then a 15-bit directory index. A successful response carries `rsp_paddr = {frame, offset}`, and its low OFF_W bits equal the request's offset.
- R2: The first memory read of a walk goes to `base + 4*directory_index`. The base used is the value the register holds in the cycle the request is accepted.
- R3: Entries are 32 bits wide. Bit 0 is the present bit and bits [31:9] hold a frame number. The second read goes to `{directory frame, table index, 2'b00}`, and the table entry's frame becomes the result's frame.
- R4: A directory entry with bit 0 clear ends the walk after exactly one memory read. The response has `rsp_fault=1`, `rsp_fault_lvl=0` and `rsp_paddr=0`.
- R5: A table entry with bit 0 clear ends the walk after exactly two memory reads. The response has `rsp_fault=1`, `rsp_fault_lvl=1` and `rsp_paddr=0`.
- R6: At most one memory read is in flight. A new `mem_req_valid` appears only after the previous read's data has been accepted. A stalled read request holds its address.
- R7: `req_ready` is high only while no walk is in progress and no response is pending. A pending response holds all of its fields until `rsp_ready`.
- R8: `base_we` loads `base_wdata` only while `req_ready` is high, and writes at any other time are dropped. A write in the same cycle as an accepted request does not affect that request, but it does govern the next one.
- R9: After reset, `req_ready=1`, `rsp_valid=0` and `mem_req_valid=0`, and the base register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Base register write strobe |
| base_wdata | input | 32 | New directory base address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 31 | Virtual address to translate |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer accepts the result |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Walk ended on a non-present entry |
| rsp_fault_lvl | output | 1 | Fault level: 0 directory, 1 table |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker accepts the read data |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
A base register write and the acceptance of a translation request can land in the same cycle. The bench provokes this by holding `base_we` high together with `req_valid` while the walker is idle. The scoreboard then expects that request to be translated through the old directory and the following request through the new one. The opposite case is a write strobed while a walk is in progress. It is judged through the next translation, which must still use the old directory.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  typedef enum logic [2:0] {
    WK_IDLE,
    WK_DIR_REQ,
    WK_DIR_WAIT,
    WK_TBL_REQ,
    WK_TBL_WAIT,
    WK_REPLY
  } walk_state_e;

  typedef enum logic {
    LVL_DIR = 1'b0,
    LVL_TBL = 1'b1
  } walk_lvl_e;

endpackage

// File: rtl/pgwalk_base.sv
module pgwalk_base #(
  parameter int          PA_W     = 32,
  parameter logic [31:0] BASE_RST = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PA_W-1:0] wr_data,
  input  logic            idle,
  output logic [PA_W-1:0] base_q
);

  // Writes land only when no walk is running; others are dropped.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= PA_W'(BASE_RST);
    end else if (wr_en && idle) begin
      base_q <= wr_data;
    end
  end

endmodule

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int  VA_W   = 31,
  parameter int  PA_W   = 32,
  parameter int  OFF_W  = 9,
  parameter int  PTE_LG = 2,
  localparam int TBL_W  = OFF_W - PTE_LG,
  localparam int DIR_W  = VA_W - OFF_W - TBL_W,
  localparam int LO_W   = OFF_W + TBL_W,
  localparam int FRM_W  = PA_W - OFF_W
) (
  input  logic [DIR_W-1:0] dir_idx,
  input  logic [PA_W-1:0]  base,
  input  logic [LO_W-1:0]  held_lo,
  input  logic [FRM_W-1:0] frame,
  output logic [PA_W-1:0]  dir_addr,
  output logic [PA_W-1:0]  tbl_addr,
  output logic [PA_W-1:0]  phys_addr
);

  logic [DIR_W+PTE_LG-1:0] dir_byte_off;
  logic [TBL_W-1:0]        tbl_idx;
  logic [OFF_W-1:0]        page_off;

  assign dir_byte_off = {dir_idx, {PTE_LG{1'b0}}};
  assign tbl_idx      = held_lo[LO_W-1:OFF_W];
  assign page_off     = held_lo[OFF_W-1:0];

  // Directory may sit anywhere, so it needs an adder.
  assign dir_addr  = base + (PA_W)'(dir_byte_off);
  // A table fills one page, so its entry address is pure concatenation.
  assign tbl_addr  = {frame, tbl_idx, {PTE_LG{1'b0}}};
  assign phys_addr = {frame, page_off};

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic mem_req_valid,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  output logic mem_rsp_ready,
  input  logic entry_present,
  output logic rsp_valid,
  input  logic rsp_ready,
  output logic take_req,
  output logic take_frame,
  output logic take_fault,
  output logic sel_tbl
);

  walk_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    take_req   = 1'b0;
    take_frame = 1'b0;
    take_fault = 1'b0;
    unique case (state_q)
      WK_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = WK_DIR_REQ;
        end
      end
      WK_DIR_REQ: begin
        if (mem_req_ready) state_d = WK_DIR_WAIT;
      end
      WK_DIR_WAIT: begin
        if (mem_rsp_valid) begin
          if (entry_present) begin
            take_frame = 1'b1;
            state_d    = WK_TBL_REQ;
          end else begin
            take_fault = 1'b1;
            state_d    = WK_REPLY;
          end
        end
      end
      WK_TBL_REQ: begin
        if (mem_req_ready) state_d = WK_TBL_WAIT;
      end
      WK_TBL_WAIT: begin
        if (mem_rsp_valid) begin
          take_frame = entry_present;
          take_fault = !entry_present;
          state_d    = WK_REPLY;
        end
      end
      WK_REPLY: begin
        if (rsp_ready) state_d = WK_IDLE;
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= WK_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready     = (state_q == WK_IDLE);
  assign mem_req_valid = (state_q == WK_DIR_REQ) || (state_q == WK_TBL_REQ);
  assign mem_rsp_ready = (state_q == WK_DIR_WAIT) || (state_q == WK_TBL_WAIT);
  assign rsp_valid     = (state_q == WK_REPLY);
  assign sel_tbl       = (state_q == WK_TBL_REQ) || (state_q == WK_TBL_WAIT);

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int          VA_W     = 31,
  parameter int          PA_W     = 32,
  parameter int          OFF_W    = 9,
  parameter int          PTE_W    = 32,
  parameter logic [31:0] BASE_RST = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [PA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic             rsp_fault_lvl,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [PTE_W-1:0] mem_rsp_data
);

  localparam int PTE_LG = $clog2(PTE_W / 8);
  localparam int TBL_W  = OFF_W - PTE_LG;
  localparam int DIR_W  = VA_W - OFF_W - TBL_W;
  localparam int LO_W   = OFF_W + TBL_W;
  localparam int FRM_W  = PA_W - OFF_W;

  logic [PA_W-1:0]  base_q;
  logic             take_req, take_frame, take_fault, sel_tbl;
  logic             entry_present;
  logic [FRM_W-1:0] entry_frame;
  logic [LO_W-1:0]  va_lo_q;
  logic [PA_W-1:0]  dir_addr_q;
  logic [FRM_W-1:0] frame_q;
  logic             fault_q;
  walk_lvl_e        lvl_q;
  logic [PA_W-1:0]  dir_addr_c, tbl_addr_c, phys_c;
  logic             unused_pte_bits;

  assign entry_present   = mem_rsp_data[0];
  assign entry_frame     = mem_rsp_data[PTE_W-1 -: FRM_W];
  assign unused_pte_bits = ^mem_rsp_data[PTE_W-FRM_W-1:1];

  pgwalk_base #(.PA_W(PA_W), .BASE_RST(BASE_RST)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_we),
    .wr_data (base_wdata),
    .idle    (req_ready),
    .base_q  (base_q)
  );

  pgwalk_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .entry_present (entry_present),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .take_req      (take_req),
    .take_frame    (take_frame),
    .take_fault    (take_fault),
    .sel_tbl       (sel_tbl)
  );

  pgwalk_addr #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_LG(PTE_LG)) u_addr (
    .dir_idx   (req_vaddr[VA_W-1 -: DIR_W]),
    .base      (base_q),
    .held_lo   (va_lo_q),
    .frame     (frame_q),
    .dir_addr  (dir_addr_c),
    .tbl_addr  (tbl_addr_c),
    .phys_addr (phys_c)
  );

  // The directory address is fixed at acceptance, so a same-cycle base
  // write cannot leak into the walk in progress.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_lo_q    <= '0;
      dir_addr_q <= '0;
      frame_q    <= '0;
      fault_q    <= 1'b0;
      lvl_q      <= LVL_DIR;
    end else begin
      if (take_req) begin
        va_lo_q    <= req_vaddr[LO_W-1:0];
        dir_addr_q <= dir_addr_c;
        fault_q    <= 1'b0;
        lvl_q      <= LVL_DIR;
      end
      if (take_frame) frame_q <= entry_frame;
      if (take_fault) begin
        fault_q <= 1'b1;
        lvl_q   <= sel_tbl ? LVL_TBL : LVL_DIR;
      end
    end
  end

  assign mem_req_addr  = sel_tbl ? tbl_addr_c : dir_addr_q;
  assign rsp_paddr     = fault_q ? '0 : phys_c;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = (lvl_q == LVL_TBL);

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int VA_W  = 31,
  parameter int PA_W  = 32,
  parameter int OFF_W = 9,
  parameter int PTE_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            base_we,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic            rsp_fault_lvl,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            mem_rsp_ready,
  input logic [PA_W-1:0] base_q
);

  localparam int PTE_LG = $clog2(PTE_W / 8);
  localparam int TBL_W  = OFF_W - PTE_LG;
  localparam int DIR_W  = VA_W - OFF_W - TBL_W;

  logic             in_flight_q;
  logic             first_rd_q;
  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  want_dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_flight_q <= 1'b0;
      first_rd_q  <= 1'b0;
      off_q       <= '0;
      want_dir_q  <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready)      in_flight_q <= 1'b1;
      else if (mem_rsp_valid && mem_rsp_ready) in_flight_q <= 1'b0;
      if (req_valid && req_ready) begin
        first_rd_q <= 1'b1;
        off_q      <= req_vaddr[OFF_W-1:0];
        want_dir_q <= base_q + (PA_W)'({req_vaddr[VA_W-1 -: DIR_W], {PTE_LG{1'b0}}});
      end else if (mem_req_valid && mem_req_ready) begin
        first_rd_q <= 1'b0;
      end
    end
  end

  // R1: offset passes through unchanged
  assert_offset_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_paddr[OFF_W-1:0] == off_q);

  // R2: first read targets the directory slot chosen at acceptance
  assert_dir_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && first_rd_q |-> mem_req_addr == want_dir_q);

  // R4, R5: a fault carries a zero address
  assert_fault_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R6: single outstanding read
  assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !in_flight_q);

  // R6: stalled read request holds
  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7: pending response holds
  assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=>
      rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_fault_lvl));

  // R7: ready only when nothing is in progress
  assert_ready_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid && !mem_req_valid && !mem_rsp_ready && !in_flight_q);

  // R8: writes while busy leave the base alone
  assert_busy_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    base_we && !req_ready |=> $stable(base_q));

endmodule

bind pgwalk_top pgwalk_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .PTE_W(PTE_W)
) u_pgwalk_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .base_we       (base_we),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_fault     (rsp_fault),
  .rsp_fault_lvl (rsp_fault_lvl),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .mem_rsp_ready (mem_rsp_ready),
  .base_q        (base_q)
);

// File: tb/test_pgwalk_top.sv
`timescale 1ns/1ps
module test_pgwalk_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [30:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        rsp_fault_lvl;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  typedef struct {
    logic [31:0] pa;
    bit          flt;
    bit          lvl;
    int          reads;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] tb_base = 32'h0;
  logic [31:0] mem [logic [31:0]];
  int          reads_total = 0;
  int          reads_seen = 0;
  bit          overlap = 1'b0;

  localparam logic [31:0] BASE_A = 32'h0004_0000;
  localparam logic [31:0] BASE_B = 32'h0006_0000;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  function automatic logic [22:0] frm(input logic [22:0] tf, input int t);
    return (tf * 23'd131 + 23'(t) * 23'd7) ^ 23'h155;
  endfunction

  function automatic void put_dir(input logic [31:0] b, input int d,
                                  input logic [22:0] tf, input bit v);
    mem[b + 32'(d) * 4] = {tf, 8'h00, v};
  endfunction

  function automatic void fill_tbl(input logic [22:0] tf);
    for (int t = 0; t < 128; t++)
      mem[{tf, 7'(t), 2'b00}] = {frm(tf, t), 8'h00, (t % 4) != 3};
  endfunction

  // Reference walk built from the requirement text.
  function automatic exp_t model(input logic [30:0] va, input logic [31:0] b,
                                 input string tag);
    exp_t e;
    logic [31:0] de, te;
    e.tag = tag;
    de = rd(b + {15'd0, va[30:16], 2'b00});
    if (!de[0]) begin
      e.pa = '0; e.flt = 1'b1; e.lvl = 1'b0; e.reads = 1;
      return e;
    end
    te = rd({de[31:9], va[15:9], 2'b00});
    if (!te[0]) begin
      e.pa = '0; e.flt = 1'b1; e.lvl = 1'b1; e.reads = 2;
      return e;
    end
    e.pa = {te[31:9], va[8:0]}; e.flt = 1'b0; e.lvl = 1'b0; e.reads = 2;
    return e;
  endfunction

  function automatic logic [30:0] mkva(input int d, input int t, input int o);
    return {15'(d), 7'(t), 9'(o)};
  endfunction

  task automatic wait_idle();
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  // Driver: push the expectation, then hold the request until taken.
  task automatic send(input logic [30:0] va, input string tag,
                      input bit we = 1'b0, input logic [31:0] wd = '0);
    if (we) wait_idle();
    exp_q.push_back(model(va, tb_base, tag));
    req_valid = 1'b1;
    req_vaddr = va;
    base_we   = we;
    base_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    base_we   = 1'b0;
    if (we) tb_base = wd;
  endtask

  task automatic set_base(input logic [31:0] v);
    wait_idle();
    base_we = 1'b1; base_wdata = v;
    @(negedge clk);
    base_we = 1'b0;
    tb_base = v;
  endtask

  // Memory model with varying back-pressure and latency.
  logic [15:0] lf;
  logic        pend;
  logic [31:0] pend_addr;
  logic [1:0]  dly;
  always @(posedge clk) begin
    if (!rst_n) begin
      lf <= 16'hACE1; pend <= 1'b0; dly <= '0;
      mem_req_ready <= 1'b0; mem_rsp_valid <= 1'b0;
    end else begin
      lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      mem_req_ready <= lf[0] | lf[1];
      if (mem_req_valid && mem_req_ready) begin
        if (pend || mem_rsp_valid) overlap <= 1'b1;
        pend <= 1'b1; pend_addr <= mem_req_addr; dly <= lf[3:2];
        reads_total <= reads_total + 1;
      end else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1; mem_rsp_data <= rd(pend_addr); pend <= 1'b0;
        end else dly <= dly - 1'b1;
      end
      if (mem_rsp_valid && mem_rsp_ready) mem_rsp_valid <= 1'b0;
    end
  end

  // Monitor: owns rsp_ready, pops and compares at each handshake.
  int mcyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      mcyc++;
      rsp_ready = (mcyc % 3) != 0;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected response", rsp_paddr, 32'h0);
        end else begin
          e = exp_q.pop_front();
          check(rsp_paddr == e.pa, {"R1 R3 paddr ", e.tag}, rsp_paddr, e.pa);
          check(rsp_fault == e.flt, {"R4 R5 fault ", e.tag}, 32'(rsp_fault), 32'(e.flt));
          if (e.flt)
            check(rsp_fault_lvl == e.lvl, {"R4 R5 level ", e.tag},
                  32'(rsp_fault_lvl), 32'(e.lvl));
          check(reads_total - reads_seen == e.reads, {"R4 R5 read count ", e.tag},
                32'(reads_total - reads_seen), 32'(e.reads));
          reads_seen = reads_total;
        end
      end
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    logic [31:0] s;
    // directory under base 0 (reset value), A and B; tables above 0x80000
    put_dir(32'h0, 0, 23'h400, 1'b1);
    put_dir(32'h0, 3, 23'h401, 1'b1);
    put_dir(32'h0, 32767, 23'h402, 1'b1);
    put_dir(32'h0, 5, 23'h403, 1'b0);
    put_dir(BASE_A, 0, 23'h410, 1'b1);
    put_dir(BASE_A, 3, 23'h411, 1'b1);
    put_dir(BASE_B, 3, 23'h420, 1'b1);
    fill_tbl(23'h400); fill_tbl(23'h401); fill_tbl(23'h402);
    fill_tbl(23'h410); fill_tbl(23'h411); fill_tbl(23'h420);

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 req_ready after reset", 32'(req_ready), 32'h1);
    check(rsp_valid == 1'b0, "R9 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    check(mem_req_valid == 1'b0, "R9 mem_req_valid after reset", 32'(mem_req_valid), 32'h0);

    // R9: reset base 0 is used; R1/R3 ordinary translations
    send(mkva(3, 5, 9'h1AB), "R9 base0 d3 t5");
    send(mkva(0, 0, 0), "R1 d0 t0 off0");
    send(mkva(32767, 127, 511), "R2 top directory slot");
    send(mkva(3, 3, 7), "R5 absent table entry");
    send(mkva(5, 1, 2), "R4 directory present bit clear");
    send(mkva(6, 1, 2), "R4 empty directory slot");

    s = 32'h1234_5678;
    for (int i = 0; i < 24; i++) begin
      int d;
      s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
      case (s[2:0])
        3'd0, 3'd1: d = 0;
        3'd2, 3'd3: d = 3;
        3'd4, 3'd5: d = 32767;
        3'd6:       d = 5;
        default:    d = 6;
      endcase
      send(mkva(d, int'(s[12:6]), int'(s[21:13])), "R3 mixed pattern");
    end

    // R8: idle write, then write in the same cycle as a request
    set_base(BASE_A);
    send(mkva(3, 5, 9'h0F0), "R8 idle write takes effect");
    send(mkva(3, 6, 9'h011), "R8 same-cycle write uses old base", 1'b1, BASE_B);
    send(mkva(3, 6, 9'h011), "R8 next request uses new base");

    // R8: write while busy is dropped
    send(mkva(3, 9, 9'h100), "R8 walk before busy write");
    if (!req_ready) begin
      base_we = 1'b1; base_wdata = BASE_A;
      @(negedge clk);
      base_we = 1'b0;
    end
    send(mkva(3, 9, 9'h101), "R8 busy write ignored");
    send(mkva(0, 1, 1), "R4 slot absent under B");

    wait_idle();
    repeat (4) @(negedge clk);
    check(overlap == 1'b0, "R6 second read while one in flight", 32'(overlap), 32'h0);
    check(exp_q.size() == 0, "R7 responses outstanding", 32'(exp_q.size()), 32'h0);
    finish_up();
  end

endmodule